// File: doc/BRIEF.md
# Bidirectional Signed-Amount Barrel Shifter

This block shifts either a 40-bit accumulator word or a 16-bit bus word by a signed amount. The sign of the amount chooses the direction: a positive amount shifts right and a negative amount shifts left. Right shifts can fill from the top with the sign bit or with zeros. The shift takes one pass through a logarithmic shifter, and an optional output register sits behind it.

A bus word is first placed inside a 40-bit frame. The position depends on the direction, so the 16-bit result can always be read from one fixed window of the shifted frame. A right shift drops the bus word into the middle window and lets its low bits fall toward the bottom. A left shift puts the bus word at the bottom and pushes it up into the window. Amounts outside the legal range are clamped to the nearest legal value rather than wrapped.

Top module: `bidir_shifter`

## Requirements
- R1: With a shift amount of zero, the accumulator source gives `res_acc` equal to `acc_in`, and the bus source gives `res_bus` equal to `bus_in`.
- R2: A negative amount shifts the frame left by its magnitude. Zeros always enter at bit 0 and bits pushed past bit 39 are lost.
- R3: A positive amount shifts the frame right by that amount. When `arith` is 1, copies of frame bit 39 enter from the top.
- R4: A positive amount with `arith` at 0 shifts zeros in from the top.
- R5: For the bus source (`src_sel` = 1) and an amount of zero or more, the frame is built in this order before the shift: bits 31:16 hold `bus_in`, bits 15:0 are zero, and bits 39:32 are `bus_in[15]` when `arith` = 1 or zero otherwise.
- R6: For the bus source and a negative amount, bits 15:0 of the frame hold `bus_in`. Bits 39:16 are `bus_in[15]` when `arith` = 1 and zero otherwise. The frame is then shifted left.
- R7: For both sources, `res_acc` is the whole 40-bit shifted frame and `res_bus` is its bits 31:16. The accumulator source (`src_sel` = 0) uses `acc_in` as the frame unchanged.
- R8: `amt` is a 6-bit two's-complement value. Any amount above +15 acts as +15, and any amount below -16 acts as -16.
- R9: With the default `REG_OUT` = 1, both results appear one clock after the inputs are sampled. A synchronous active-high `rst` clears both results to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| src_sel | input | 1 | Operand source: 0 selects the accumulator word, 1 selects the bus word |
| acc_in | input | 40 | Accumulator operand |
| bus_in | input | 16 | Bus operand |
| amt | input | 6 | Signed shift amount: positive shifts right, negative shifts left |
| arith | input | 1 | 1 fills with the sign, 0 fills with zeros |
| res_acc | output | 40 | Full shifted frame |
| res_bus | output | 16 | Bits 31:16 of the shifted frame |

## Verification
The assertions run on every cycle and cover these properties:
- an amount of zero leaves the word unchanged;
- a left shift always clears bit 0;
- a right shift fills bit 39 with the sign or with zero, as `arith` selects;
- a logical right shift of a bus word clears the guard bits;
- a bus word shifted by the clamped minimum lands exactly in the result window.

Only the bench's scenarios can show the exact bit values for every amount. These cover the full random spread of amounts and operands, the clamping of out-of-range amounts at both ends, the one-cycle latency and the cleared reset state.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    typedef enum logic {
        SRC_ACC = 1'b0,
        SRC_BUS = 1'b1
    } src_e;

    typedef enum logic {
        DIR_RIGHT = 1'b0,
        DIR_LEFT  = 1'b1
    } dir_e;

    typedef enum logic {
        FILL_ZERO = 1'b0,
        FILL_SIGN = 1'b1
    } fill_e;

    typedef struct packed {
        dir_e  dir;
        fill_e fill;
    } shift_ctl_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int clamp_int(input int v, input int lo, input int hi);
        int r;
        r = v;
        if (r > hi) r = hi;
        if (r < lo) r = lo;
        return r;
    endfunction

endpackage

// File: rtl/bsh_amt_decode.sv
module bsh_amt_decode
    import bsh_pkg::*;
#(
    parameter int AMT_W = 6,
    parameter int MAX_R = 15,
    parameter int MAX_L = 16,
    parameter int MAG_W = 5
) (
    input  logic signed [AMT_W-1:0] amt,
    input  logic                    arith,
    output shift_ctl_t              ctl,
    output logic [MAG_W-1:0]        mag
);

    int lim;

    always_comb begin
        // R8: saturate the requested amount into the legal window
        lim      = clamp_int(int'(amt), -MAX_L, MAX_R);
        ctl.dir  = (lim < 0) ? DIR_LEFT : DIR_RIGHT;
        ctl.fill = (lim >= 0 && arith) ? FILL_SIGN : FILL_ZERO;
        mag      = MAG_W'((lim < 0) ? -lim : lim);
    end

endmodule

// File: rtl/bsh_align.sv
module bsh_align
    import bsh_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int BUS_W  = 16,
    parameter int BUS_LO = 16
) (
    input  src_e             src,
    input  dir_e             dir,
    input  logic             arith,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [BUS_W-1:0] bus_in,
    output logic [ACC_W-1:0] frame
);

    localparam int BUS_HI = BUS_LO + BUS_W;

    logic             ext_bit;
    logic [ACC_W-1:0] right_frame;
    logic [ACC_W-1:0] left_frame;

    assign ext_bit = arith & bus_in[BUS_W-1];

    // R5: bus word centred in the result window, low lane cleared
    for (genvar i = 0; i < ACC_W; i++) begin : g_right
        if (i < BUS_LO) begin : g_low
            assign right_frame[i] = 1'b0;
        end else if (i < BUS_HI) begin : g_mid
            assign right_frame[i] = bus_in[i-BUS_LO];
        end else begin : g_top
            assign right_frame[i] = ext_bit;
        end
    end

    // R6: bus word at the bottom, everything above extended
    for (genvar i = 0; i < ACC_W; i++) begin : g_left
        if (i < BUS_W) begin : g_low
            assign left_frame[i] = bus_in[i];
        end else begin : g_top
            assign left_frame[i] = ext_bit;
        end
    end

    always_comb begin
        if (src == SRC_ACC) begin
            frame = acc_in;
        end else if (dir == DIR_LEFT) begin
            frame = left_frame;
        end else begin
            frame = right_frame;
        end
    end

endmodule

// File: rtl/bsh_core.sv
module bsh_core
    import bsh_pkg::*;
#(
    parameter int W     = 40,
    parameter int MAG_W = 5
) (
    input  logic [W-1:0]     din,
    input  dir_e             dir,
    input  logic             fill_bit,
    input  logic [MAG_W-1:0] mag,
    output logic [W-1:0]     dout
);

    logic [W-1:0] din_rev;
    logic [W-1:0] st [MAG_W+1];
    logic [W-1:0] st_rev;

    // A left shift is a right shift of the bit-reversed word
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign din_rev[i] = din[W-1-i];
        assign st_rev[i]  = st[MAG_W][W-1-i];
    end

    assign st[0] = (dir == DIR_LEFT) ? din_rev : din;

    for (genvar s = 0; s < MAG_W; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign st[s+1] = mag[s] ? {{SH{fill_bit}}, st[s][W-1:SH]} : st[s];
    end

    assign dout = (dir == DIR_LEFT) ? st_rev : st[MAG_W];

endmodule

// File: rtl/bsh_out_stage.sv
module bsh_out_stage #(
    parameter int W       = 40,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= d;
        end
    end else begin : g_comb
        logic unused_ok;
        assign unused_ok = clk ^ rst;
        assign q = d;
    end

endmodule

// File: rtl/bidir_shifter.sv
module bidir_shifter
    import bsh_pkg::*;
#(
    parameter int ACC_W   = 40,
    parameter int BUS_W   = 16,
    parameter int BUS_LO  = 16,
    parameter int AMT_W   = 6,
    parameter int MAX_R   = 15,
    parameter int MAX_L   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    src_sel,
    input  logic [ACC_W-1:0]        acc_in,
    input  logic [BUS_W-1:0]        bus_in,
    input  logic signed [AMT_W-1:0] amt,
    input  logic                    arith,
    output logic [ACC_W-1:0]        res_acc,
    output logic [BUS_W-1:0]        res_bus
);

    localparam int MAG_W = $clog2(max_int(MAX_R, MAX_L) + 1);

    shift_ctl_t       ctl;
    logic [MAG_W-1:0] mag;
    logic [ACC_W-1:0] frame;
    logic [ACC_W-1:0] shifted;
    logic             fill_bit;
    src_e             src;

    assign src = src_e'(src_sel);

    bsh_amt_decode #(
        .AMT_W(AMT_W), .MAX_R(MAX_R), .MAX_L(MAX_L), .MAG_W(MAG_W)
    ) u_dec (
        .amt(amt), .arith(arith), .ctl(ctl), .mag(mag)
    );

    bsh_align #(
        .ACC_W(ACC_W), .BUS_W(BUS_W), .BUS_LO(BUS_LO)
    ) u_align (
        .src(src), .dir(ctl.dir), .arith(arith),
        .acc_in(acc_in), .bus_in(bus_in), .frame(frame)
    );

    // R3/R4: top fill follows the frame sign only for arithmetic right shifts
    assign fill_bit = (ctl.fill == FILL_SIGN) ? frame[ACC_W-1] : 1'b0;

    bsh_core #(
        .W(ACC_W), .MAG_W(MAG_W)
    ) u_core (
        .din(frame), .dir(ctl.dir), .fill_bit(fill_bit),
        .mag(mag), .dout(shifted)
    );

    bsh_out_stage #(
        .W(ACC_W), .REG_OUT(REG_OUT)
    ) u_out (
        .clk(clk), .rst(rst), .d(shifted), .q(res_acc)
    );

    // R7: the narrow result is a fixed window of the wide one
    assign res_bus = res_acc[BUS_LO +: BUS_W];

endmodule

// File: rtl/bsh_chk.sv
module bsh_chk #(
    parameter int ACC_W   = 40,
    parameter int BUS_W   = 16,
    parameter int BUS_LO  = 16,
    parameter int AMT_W   = 6,
    parameter int MAX_R   = 15,
    parameter int MAX_L   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    src_sel,
    input logic [ACC_W-1:0]        acc_in,
    input logic [BUS_W-1:0]        bus_in,
    input logic signed [AMT_W-1:0] amt,
    input logic                    arith,
    input logic [ACC_W-1:0]        res_acc,
    input logic [BUS_W-1:0]        res_bus
);

    logic                    q_vld;
    logic                    q_src;
    logic [ACC_W-1:0]        q_acc;
    logic [BUS_W-1:0]        q_bus;
    logic signed [AMT_W-1:0] q_amt;
    logic                    q_ar;

    if (REG_OUT) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst) begin
                q_vld <= 1'b0;
                q_src <= 1'b0;
                q_acc <= '0;
                q_bus <= '0;
                q_amt <= '0;
                q_ar  <= 1'b0;
            end else begin
                q_vld <= 1'b1;
                q_src <= src_sel;
                q_acc <= acc_in;
                q_bus <= bus_in;
                q_amt <= amt;
                q_ar  <= arith;
            end
        end
    end else begin : g_pass
        assign q_vld = 1'b1;
        assign q_src = src_sel;
        assign q_acc = acc_in;
        assign q_bus = bus_in;
        assign q_amt = amt;
        assign q_ar  = arith;
    end

    AST_ACC_ZERO_KEEP: assert property (@(posedge clk) disable iff (rst)
        (q_vld && !q_src && q_amt == 0) |-> (res_acc == q_acc)); // R1

    AST_BUS_ZERO_KEEP: assert property (@(posedge clk) disable iff (rst)
        (q_vld && q_src && q_amt == 0) |-> (res_bus == q_bus)); // R1

    AST_LEFT_LSB_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (q_vld && q_amt < 0) |-> (res_acc[0] == 1'b0)); // R2

    AST_RIGHT_SIGN_TOP: assert property (@(posedge clk) disable iff (rst)
        (q_vld && !q_src && q_amt > 0 && q_ar) |-> (res_acc[ACC_W-1] == q_acc[ACC_W-1])); // R3

    AST_RIGHT_ZERO_TOP: assert property (@(posedge clk) disable iff (rst)
        (q_vld && !q_src && q_amt > 0 && !q_ar) |-> (res_acc[ACC_W-1] == 1'b0)); // R4

    AST_BUS_GUARD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (q_vld && q_src && q_amt >= 0 && !q_ar) |-> (res_acc[ACC_W-1:BUS_LO+BUS_W] == '0)); // R5

    // With the default geometry the clamped left limit equals the window offset
    AST_CLAMP_LEFT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (q_vld && q_src && MAX_L == BUS_LO && int'(q_amt) <= -MAX_L) |-> (res_bus == q_bus)); // R8

endmodule

bind bidir_shifter bsh_chk #(
    .ACC_W(ACC_W), .BUS_W(BUS_W), .BUS_LO(BUS_LO), .AMT_W(AMT_W),
    .MAX_R(MAX_R), .MAX_L(MAX_L), .REG_OUT(REG_OUT)
) u_chk (
    .clk(clk), .rst(rst), .src_sel(src_sel), .acc_in(acc_in),
    .bus_in(bus_in), .amt(amt), .arith(arith),
    .res_acc(res_acc), .res_bus(res_bus)
);

// File: tb/sim_bidir_shifter.sv
module sim_bidir_shifter;

    localparam int CLK_P = 10;
    localparam int AW    = 40;
    localparam int BW    = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          src_sel = 1'b0;
    logic [AW-1:0] acc_in = '0;
    logic [BW-1:0] bus_in = '0;
    logic signed [5:0] amt = '0;
    logic          arith = 1'b0;
    logic [AW-1:0] res_acc;
    logic [BW-1:0] res_bus;

    int n_run  = 0;
    int n_fail = 0;
    logic [AW-1:0] prev_exp = '0;

    always #(CLK_P/2) clk = ~clk;

    bidir_shifter u0 (
        .clk(clk), .rst(rst), .src_sel(src_sel), .acc_in(acc_in),
        .bus_in(bus_in), .amt(amt), .arith(arith),
        .res_acc(res_acc), .res_bus(res_bus)
    );

    function automatic logic [AW-1:0] ref_shift(input logic s, input logic [AW-1:0] a,
                                                input logic [BW-1:0] b, input int k_in,
                                                input logic ar);
        int k;
        logic [AW-1:0] e;
        k = k_in;
        if (k > 15)  k = 15;
        if (k < -16) k = -16;
        if (!s)          e = a;
        else if (k >= 0) e = {(ar ? {8{b[15]}} : 8'h00), b, 16'h0000};
        else             e = {(ar ? {24{b[15]}} : 24'h000000), b};
        if (k >= 0) return ar ? AW'($signed(e) >>> k) : (e >> k);
        return e << (-k);
    endfunction

    function automatic string tag_of(input logic s, input int k, input logic ar);
        if (k > 15 || k < -16) return "R8";
        if (k == 0)  return "R1";
        if (k < 0)   return s ? "R6" : "R2";
        if (s)       return "R5";
        return ar ? "R3" : "R4";
    endfunction

    task automatic check40(input string r, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s res_acc got=%h exp=%h", r, got, exp);
        end
    endtask

    task automatic check16(input string r, input logic [BW-1:0] got, input logic [BW-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s res_bus got=%h exp=%h", r, got, exp);
        end
    endtask

    // Drive at a falling edge, check old value before the rising edge,
    // then check the new value at the next falling edge.
    task automatic apply(input logic s, input logic [AW-1:0] a, input logic [BW-1:0] b,
                         input int k, input logic ar);
        logic [AW-1:0] e;
        e = ref_shift(s, a, b, k, ar);
        src_sel = s; acc_in = a; bus_in = b; amt = 6'(k); arith = ar;
        #1;
        check40("R9", res_acc, prev_exp);
        @(negedge clk);
        check40(tag_of(s, k, ar), res_acc, e);
        check16("R7", res_bus, e[31:16]);
        prev_exp = e;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired, R9 timing not reached");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        acc_in = 40'hFF_FFFF_FFFF; bus_in = 16'hFFFF; amt = -6'sd3; arith = 1'b1;
        repeat (3) @(negedge clk);
        check40("R9", res_acc, '0);
        check16("R9", res_bus, '0);
        rst = 1'b0;
        prev_exp = '0;

        // directed corner cases
        apply(1'b0, 40'h80_1234_5678, 16'h0, 0, 1'b1);    // R1 acc unchanged
        apply(1'b1, 40'h0, 16'hBEEF, 0, 1'b0);            // R1 bus unchanged
        apply(1'b0, 40'h80_0000_0000, 16'h0, 15, 1'b1);   // R3 sign fill
        apply(1'b0, 40'h80_0000_0000, 16'h0, 15, 1'b0);   // R4 zero fill
        apply(1'b0, 40'hFF_8000_0001, 16'h0, -16, 1'b1);  // R2 left max
        apply(1'b0, 40'h12_3456_789A, 16'h0, 31, 1'b1);   // R8 clamp high
        apply(1'b0, 40'h12_3456_789A, 16'h0, -32, 1'b0);  // R8 clamp low
        apply(1'b1, 40'h0, 16'h8001, 4, 1'b1);            // R5 bus right arith
        apply(1'b1, 40'h0, 16'h8001, 4, 1'b0);            // R5 bus right logical
        apply(1'b1, 40'h0, 16'hA5C3, -16, 1'b0);          // R6 bus lands in window
        apply(1'b1, 40'h0, 16'h9234, -3, 1'b1);           // R6 sign-filled high word
        apply(1'b1, 40'h0, 16'h9234, -3, 1'b0);           // R6 zero-filled high word
        apply(1'b1, 40'h0, 16'h4321, -20, 1'b1);          // R8 bus clamp low

        // random mix
        for (int i = 0; i < 400; i++) begin
            apply(1'($urandom), {8'($urandom), 32'($urandom)}, 16'($urandom),
                  int'($signed(6'($urandom))), 1'($urandom));
        end

        // reset clears registered results
        rst = 1'b1;
        @(negedge clk);
        check40("R9", res_acc, '0);
        check16("R9", res_bus, '0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule